// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-side front end of a small serial EEPROM. It samples the two-wire clock and data lines with the system clock and recognises START and STOP conditions. After a START it shifts in a control byte and compares its upper nibble with a fixed device code. On a match it acknowledges. A write transfer then takes a word address into an address pointer and passes every later data byte, with its target address, to a page write controller. A read transfer shifts memory data out to the master, one byte after another.

The engine never holds the clock low and never drives SDA high. Its only bus output is an open-drain enable that pulls SDA low. The bus is watched continuously, but while the memory runs a self-timed program cycle (`busy_i` high) the engine refuses its own address. The end of every transfer is signalled by a one-cycle STOP pulse, which the write controller uses to start programming.

Top module: `eep_bus_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins reception of a new control byte from any state, including part-way through a byte. SDA is released, and the aborted byte has no effect.
- R2: The control byte is taken MSB first. Its bits 7:4 must equal the device code 4'b1010. Bits 3:1 are ignored. Bit 0 selects the direction: 0 is write, 1 is read.
- R3: For each accepted byte, `sda_oe` is high throughout the ninth SCL high phase and is released after the ninth SCL falling edge (unless a read byte follows).
- R4: If `busy_i` is high when the control byte completes, the engine does not acknowledge it and ignores the bus until the next START.
- R5: A control byte whose bits 7:4 differ from 4'b1010 gets no acknowledge. Later bytes up to the next START are not acknowledged, produce no `wr_valid` and leave `ptr_o` unchanged.
- R6: In a write, the first byte after the control byte is acknowledged and loaded into `ptr_o`.
- R7: Each later write byte is acknowledged and produces a one-cycle `wr_valid` with `wr_data` equal to the byte and `wr_addr` equal to the pointer value before the byte.
- R8: After each written byte, the low three bits of the pointer increment and wrap within the eight-byte page, while the upper bits stay constant.
- R9: In a read, the byte `rd_data_i` presented for address `ptr_o` is shifted out MSB first, and `sda_oe` changes only while SCL is low. The full pointer increments by one per byte and wraps from 8'hFF to 8'h00.
- R10: A master acknowledge (SDA low on the ninth clock) continues the read. A master NACK ends it: SDA stays released and the pointer stops advancing.
- R11: A rising SDA while SCL is high (STOP) pulses `xfer_end` for one cycle, releases SDA and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Internal program cycle running |
| ptr_o | output | 8 | Address pointer |
| wr_valid | output | 1 | One-cycle pulse: write byte ready |
| wr_addr | output | 8 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| rd_data_i | input | 8 | Memory data at `ptr_o` |
| xfer_end | output | 1 | One-cycle pulse on STOP |

## Verification
The hardest situations to reach from the ports are a START that lands inside a half-received byte and a page write long enough to wrap the low pointer bits. The bench reaches the first by sending four data bits and then issuing a START in place of the fifth rising edge. It proves the control byte that follows is byte-aligned by checking that the next word address lands in `ptr_o`. For the wrap, the bench sends ten data bytes from an address near the end of a page. For reads, it starts at 8'hFE and reads three bytes, so the full-pointer rollover appears in the returned data.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } eep_state_t;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q[0] <= 1'b1;
          sda_q[0] <= 1'b1;
        end else begin
          scl_q[0] <= scl_i;
          sda_q[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q[k] <= 1'b1;
          sda_q[k] <= 1'b1;
        end else begin
          scl_q[k] <= scl_q[k-1];
          sda_q[k] <= sda_q[k-1];
        end
      end
    end
  end

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] page_next;

  if (PAGE_W >= ADDR_W) begin : g_flat
    assign page_next = ptr + 1'b1;
  end else begin : g_paged
    logic [PAGE_W-1:0] low_next;
    assign low_next  = ptr[PAGE_W-1:0] + 1'b1;
    assign page_next = {ptr[ADDR_W-1:PAGE_W], low_next};
  end

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (load)     ptr <= load_val;
    else if (inc_page) ptr <= page_next;
    else if (inc_full) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/eep_bus_slave.sv
module eep_bus_slave #(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic [7:0]        rd_data_i,
  output logic              xfer_end
);
  import eep_pkg::*;

  localparam int BITS = 8;
  localparam logic [3:0] LAST = 4'(BITS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  eep_state_t st, after_st;
  logic [3:0] cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       m_ack;
  logic       p_load, p_inc_page, p_inc_full;
  logic [ADDR_W-1:0] ptr;

  eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst), .load(p_load), .load_val(rx_sh[ADDR_W-1:0]),
    .inc_page(p_inc_page), .inc_full(p_inc_full), .ptr(ptr)
  );

  assign ptr_o = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      after_st   <= ST_IDLE;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      m_ack      <= 1'b0;
      sda_oe     <= 1'b0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      xfer_end   <= 1'b0;
      p_load     <= 1'b0;
      p_inc_page <= 1'b0;
      p_inc_full <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      xfer_end   <= 1'b0;
      p_load     <= 1'b0;
      p_inc_page <= 1'b0;
      p_inc_full <= 1'b0;
      if (start_det) begin
        st     <= ST_CTRL;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        xfer_end <= 1'b1;
      end else begin
        unique case (st)
          ST_CTRL, ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (st == ST_CTRL) begin
                if (rx_sh[7:4] == DEV_CODE && !busy_i) begin
                  sda_oe   <= 1'b1;
                  st       <= ST_ACK;
                  after_st <= rx_sh[0] ? ST_TX : ST_ADDR;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_ADDR) begin
                p_load   <= 1'b1;
                sda_oe   <= 1'b1;
                st       <= ST_ACK;
                after_st <= ST_WDAT;
              end else begin
                wr_valid   <= 1'b1;
                wr_addr    <= ptr;
                wr_data    <= rx_sh;
                p_inc_page <= 1'b1;
                sda_oe     <= 1'b1;
                st         <= ST_ACK;
                after_st   <= ST_WDAT;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (after_st == ST_TX) begin
                tx_sh      <= rd_data_i;
                sda_oe     <= ~rd_data_i[7];
                p_inc_full <= 1'b1;
                cnt        <= '0;
              end else begin
                sda_oe <= 1'b0;
              end
              st <= after_st;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                m_ack  <= 1'b0;
                st     <= ST_TXACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IDLE;
              else       m_ack <= 1'b1;
            end else if (scl_fall && m_ack) begin
              tx_sh      <= rd_data_i;
              sda_oe     <= ~rd_data_i[7];
              p_inc_full <= 1'b1;
              cnt        <= '0;
              st         <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_bus_slave_chk.sv
module eep_bus_slave_chk (
  input logic                clk,
  input logic                rst,
  input logic                scl_s,
  input logic                start_det,
  input logic                stop_det,
  input logic                sda_oe,
  input logic                busy_i,
  input logic                wr_valid,
  input logic                xfer_end,
  input eep_pkg::eep_state_t st
);
  import eep_pkg::*;

  assert_start_release_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  assert_busy_nack_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CTRL && busy_i && !start_det && !stop_det) |=> !sda_oe);

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  assert_end_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> !xfer_end);

  assert_stop_idle_R11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == ST_IDLE && !sda_oe));
endmodule

bind eep_bus_slave eep_bus_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .busy_i(busy_i), .wr_valid(wr_valid), .xfer_end(xfer_end), .st(st)
);

// File: tb/eep_bus_slave_bench.sv
module eep_bus_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, wr_valid, xfer_end;
  logic [7:0] ptr_o, wr_addr, wr_data, rd_data;
  logic bus_sda;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] ev_addr [64];
  logic [7:0] ev_data [64];
  int ev_n = 0;
  int end_n = 0;
  int oe_viol = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;

  assign bus_sda = m_sda & ~sda_oe;
  assign rd_data = ptr_o ^ 8'hA5;

  always #4 clk = ~clk;

  eep_bus_slave u_eep_bus_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda), .sda_oe(sda_oe),
    .busy_i(busy), .ptr_o(ptr_o), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data_i(rd_data), .xfer_end(xfer_end)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid && ev_n < 64) begin
        ev_addr[ev_n] = wr_addr;
        ev_data[ev_n] = wr_data;
        ev_n++;
      end
      if (xfer_end) end_n++;
      if (sda_oe != prev_oe && scl && prev_scl) oe_viol++;
    end
    prev_oe  = sda_oe;
    prev_scl = scl;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl = 1'b0; m_sda = 1'b0; wq();
    scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output bit oe9);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0;
    end
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    acked = (bus_sda == 1'b0);
    oe9 = sda_oe;
    wq();
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl = 1'b1; wq();
      d[i] = bus_sda;
      wq();
      scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    chk("R11 reset sda_oe", sda_oe, 0);
    chk("R7 reset wr_valid", wr_valid, 0);
    chk("R6 reset ptr", ptr_o, 0);
    chk("R11 reset xfer_end", xfer_end, 0);
  endtask

  task automatic t_byte_write();
    bit a, o;
    int e0 = ev_n;
    int n0 = end_n;
    bus_start();
    send_byte(8'hA0, a, o);
    chk("R2 ctrl A0 ack", a, 1);
    chk("R3 oe high on ninth clock", o, 1);
    send_byte(8'h35, a, o);
    chk("R6 addr ack", a, 1);
    wq();
    chk("R6 ptr loaded", ptr_o, 8'h35);
    send_byte(8'hC3, a, o);
    chk("R7 data ack", a, 1);
    wq();
    chk("R3 released after ninth fall", sda_oe, 0);
    chk("R7 one write event", ev_n - e0, 1);
    chk("R7 write addr", ev_addr[e0], 8'h35);
    chk("R7 write data", ev_data[e0], 8'hC3);
    bus_stop(); wq();
    chk("R11 xfer_end pulse", end_n - n0, 1);
    chk("R11 idle after stop", sda_oe, 0);
  endtask

  task automatic t_dont_care();
    bit a, o;
    bus_start();
    send_byte(8'hAE, a, o);
    chk("R2 chip-select bits ignored", a, 1);
    bus_stop(); wq();
  endtask

  task automatic t_mismatch();
    bit a, o;
    int e0 = ev_n;
    logic [7:0] p0 = ptr_o;
    bus_start();
    send_byte(8'hB0, a, o);
    chk("R5 wrong code nack", a, 0);
    send_byte(8'h12, a, o);
    chk("R5 later byte nack", a, 0);
    send_byte(8'h77, a, o);
    chk("R5 no write event", ev_n - e0, 0);
    chk("R5 ptr unchanged", ptr_o, p0);
    bus_stop(); wq();
  endtask

  task automatic t_busy();
    bit a, o;
    int e0 = ev_n;
    busy = 1'b1;
    bus_start();
    send_byte(8'hA0, a, o);
    chk("R4 busy nack", a, 0);
    send_byte(8'h44, a, o);
    chk("R4 ignored until start", a, 0);
    chk("R4 no write event", ev_n - e0, 0);
    bus_stop(); wq();
    busy = 1'b0;
  endtask

  task automatic t_page_roll();
    bit a, o;
    int e0 = ev_n;
    bus_start();
    send_byte(8'hA0, a, o);
    send_byte(8'h2D, a, o);
    for (int k = 0; k < 10; k++) begin
      send_byte(8'(8'h40 + k), a, o);
      chk("R7 page data ack", a, 1);
    end
    bus_stop(); wq();
    chk("R8 ten events", ev_n - e0, 10);
    for (int k = 0; k < 10; k++) begin
      chk("R8 page addr wrap", ev_addr[e0 + k], (8'h28 | ((8'h2D + k) & 8'h07)));
      chk("R7 page data", ev_data[e0 + k], 8'(8'h40 + k));
    end
    chk("R8 final ptr", ptr_o, 8'h2F);
  endtask

  task automatic t_read();
    bit a, o;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, a, o);
    send_byte(8'hFE, a, o);
    bus_start();
    send_byte(8'hA1, a, o);
    chk("R2 read ctrl ack", a, 1);
    recv_byte(1'b1, d);
    chk("R9 read byte FE", d, 8'hFE ^ 8'hA5);
    recv_byte(1'b1, d);
    chk("R9 read byte FF", d, 8'hFF ^ 8'hA5);
    recv_byte(1'b0, d);
    chk("R9 read wraps to 00", d, 8'h00 ^ 8'hA5);
    wq();
    scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    chk("R10 released after nack", sda_oe, 0);
    chk("R10 ptr stopped", ptr_o, 8'h01);
    bus_stop(); wq();
  endtask

  task automatic t_restart_abort();
    bit a, o;
    bus_start();
    send_byte(8'hA0, a, o);
    send_byte(8'h60, a, o);
    for (int i = 0; i < 4; i++) begin
      m_sda = i[0]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0;
    end
    bus_start();
    chk("R1 released at restart", sda_oe, 0);
    send_byte(8'hA0, a, o);
    chk("R1 ctrl after restart ack", a, 1);
    send_byte(8'h10, a, o);
    wq();
    chk("R1 byte aligned after restart", ptr_o, 8'h10);
    bus_stop(); wq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_dont_care();
    t_mismatch();
    t_busy();
    t_page_roll();
    t_read();
    t_restart_abort();
    chk("R9 sda_oe steady while SCL high", oe_viol, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule